// File: doc/BRIEF.md
# Sub-word register access adapter

This block sits between a host bus that issues byte, halfword and word register accesses and an SD host register file that only accepts aligned 32-bit accesses. Word accesses pass through unchanged. A byte or halfword write becomes a read of the containing dword, a lane merge and a write back. Reads fetch the dword and return the addressed lane, zero-extended into the low bits of the response.

A naive read-modify-write of the dword that holds transfer mode and command would issue the command early. The same merge applied to the block size and block count dword would overwrite the other halfword. To avoid this, the adapter holds transfer-mode, block-size and block-count halfword writes in two shadow words. It commits them only when the command halfword is written: first the block dword, then the command dword, each written once. While a shadow is pending, halfword reads of those registers return the shadow contents.

Both sides use a valid/ready request handshake with one transaction outstanding. The host response is a single-cycle pulse. Downstream writes complete when their request is accepted. Downstream reads complete when a read-data pulse arrives.

Top module: `subword_reg_adapter`

## Requirements
- R1: After reset the adapter is idle: `host_ready` is 1, `dev_valid` and `host_rsp_valid` are 0, and both shadow words and both pending flags are cleared. After a reset, a halfword read of transfer mode returns the device value.
- R2: A word access (`host_size` 2 or 3) is forwarded as a single device access with the same dword address and data; a word read returns the device word.
- R3: A byte write (`host_size` 0) or a halfword write (`host_size` 1) to any register other than the four listed below is done in two steps. The adapter first reads the dword at address bits [1:0] cleared. It then writes back that dword with only the addressed lane replaced. The lane starts at bit 8 times address bits [1:0] and is 8 or 16 bits wide.
- R4: A byte read always reads the containing dword from the device and returns the addressed byte in bits [7:0], including bytes of shadowed registers.
- R5: A halfword write to transfer mode (offset 0x0C) is merged into the command shadow word and marks it pending. It causes no device access.
- R6: A halfword write to block size (0x04) or block count (0x06) is merged into the block shadow word and marks it pending. The merge base is the shadow if it is already pending; otherwise it is one device read of dword 0x04. No device write occurs.
- R7: A halfword write to command (0x0E) does the following, in order. If the block shadow is pending, the adapter first writes it to dword 0x04 and clears its flag. It then writes the command shadow, with bits [31:16] replaced by the command value, to dword 0x0C, and clears the command pending flag.
- R8: While the matching shadow is pending, a halfword read of 0x0C returns the command shadow bits [15:0], and a halfword read of 0x04 or 0x06 returns the matching block shadow half. No device access is made.
- R9: Any other halfword read, or a shadowed-register read with no pending shadow, reads the device dword and returns the addressed 16-bit lane.
- R10: `host_ready` is low from the cycle after a request is accepted until the response. Each request gets exactly one single-cycle `host_rsp_valid` pulse.
- R11: A device request held without `dev_ready` keeps its valid, write flag, address and data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host request valid |
| host_ready | output | 1 | Adapter can accept a request |
| host_write | input | 1 | 1 = write, 0 = read |
| host_addr | input | ADDR_W | Byte address |
| host_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| host_wdata | input | 32 | Write data, sub-word values in the low bits |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rsp_data | output | 32 | Read data, zero-extended lane |
| dev_valid | output | 1 | Device request valid |
| dev_ready | input | 1 | Device accepts request |
| dev_write | output | 1 | Device request is a write |
| dev_addr | output | ADDR_W | Dword-aligned device address |
| dev_wdata | output | 32 | Device write data |
| dev_rsp_valid | input | 1 | Device read data pulse |
| dev_rsp_data | input | 32 | Device read data |

## Verification
A wrong pending flag or shadow word never shows on its own. It shows at the next halfword read of a shadowed register, as a value that differs or an unexpected device read. It also shows at the next command write, as a missing, extra or reordered device write. For this reason the bench keeps a transaction-level model of both shadows. It checks every device write against the expected ordered list on the clock where it is accepted. After each response it checks that the device read count matches. A merge on the wrong lane shows at once in the written-back dword or in the returned read data.

// File: rtl/sra_pkg.sv
package sra_pkg;

  localparam int WORD_W = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    K_WORD,
    K_SUB,
    K_XFER,
    K_BLK,
    K_CMD
  } acc_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RWAIT,
    S_WR,
    S_FLUSH,
    S_CMDW,
    S_RESP
  } seq_state_e;

  function automatic logic [4:0] lane_shift(input logic [1:0] ofs);
    return {ofs, 3'b000};
  endfunction

  function automatic logic [WORD_W-1:0] lane_field(input logic [1:0] sz);
    return (sz == SZ_BYTE) ? 32'h0000_00FF : 32'h0000_FFFF;
  endfunction

  function automatic logic [WORD_W-1:0] lane_merge(input logic [WORD_W-1:0] old_dw,
                                                   input logic [WORD_W-1:0] val,
                                                   input logic [1:0]        sz,
                                                   input logic [1:0]        ofs);
    logic [WORD_W-1:0] m;
    m = lane_field(sz) << lane_shift(ofs);
    return (old_dw & ~m) | ((val & lane_field(sz)) << lane_shift(ofs));
  endfunction

  function automatic logic [WORD_W-1:0] lane_pick(input logic [WORD_W-1:0] dw,
                                                  input logic [1:0]        sz,
                                                  input logic [1:0]        ofs);
    return (dw >> lane_shift(ofs)) & lane_field(sz);
  endfunction

endpackage

// File: rtl/sra_decode.sv
module sra_decode
  import sra_pkg::*;
#(
  parameter int AW         = 8,
  parameter int BLKSZ_OFS  = 4,
  parameter int BLKCNT_OFS = 6,
  parameter int XFER_OFS   = 12,
  parameter int CMD_OFS    = 14
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  output acc_kind_e     kind
);

  localparam logic [AW-1:0] A_BLKSZ  = AW'(BLKSZ_OFS);
  localparam logic [AW-1:0] A_BLKCNT = AW'(BLKCNT_OFS);
  localparam logic [AW-1:0] A_XFER   = AW'(XFER_OFS);
  localparam logic [AW-1:0] A_CMD    = AW'(CMD_OFS);

  logic is_half;
  assign is_half = (size == SZ_HALF);

  always_comb begin
    if (size[1]) begin
      kind = K_WORD;
    end else if (is_half && addr == A_XFER) begin
      kind = K_XFER;
    end else if (is_half && (addr == A_BLKSZ || addr == A_BLKCNT)) begin
      kind = K_BLK;
    end else if (is_half && addr == A_CMD) begin
      kind = K_CMD;
    end else begin
      kind = K_SUB;
    end
  end

endmodule

// File: rtl/sra_shadow.sv
module sra_shadow
  import sra_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [WORD_W-1:0] cmd_wd,
  input  logic              cmd_set,
  input  logic              cmd_clr,
  input  logic              blk_we,
  input  logic [WORD_W-1:0] blk_wd,
  input  logic              blk_set,
  input  logic              blk_clr,
  input  logic              cmd_commit,
  output logic [WORD_W-1:0] cmd_q,
  output logic [WORD_W-1:0] blk_q,
  output logic              cmd_pend,
  output logic              blk_pend
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      blk_q    <= '0;
      cmd_pend <= 1'b0;
      blk_pend <= 1'b0;
    end else begin
      if (cmd_we) cmd_q <= cmd_wd;
      if (blk_we) blk_q <= blk_wd;
      if (cmd_clr)      cmd_pend <= 1'b0;
      else if (cmd_set) cmd_pend <= 1'b1;
      if (blk_clr)      blk_pend <= 1'b0;
      else if (blk_set) blk_pend <= 1'b1;
    end
  end

  // R7: the command dword never reaches the device while block fields wait
  a_r7_flush_before_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |-> !blk_pend);

  // R7: a command commit leaves both shadows idle
  a_r7_commit_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_commit |=> !cmd_pend && !blk_pend);

endmodule

// File: rtl/sra_seq.sv
module sra_seq
  import sra_pkg::*;
#(
  parameter int AW            = 8,
  parameter int BLK_DWORD_OFS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [AW-1:0]     host_addr,
  input  logic [1:0]        host_size,
  input  logic [WORD_W-1:0] host_wdata,
  output logic              host_rsp_valid,
  output logic [WORD_W-1:0] host_rsp_data,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_write,
  output logic [AW-1:0]     dev_addr,
  output logic [WORD_W-1:0] dev_wdata,
  input  logic              dev_rsp_valid,
  input  logic [WORD_W-1:0] dev_rsp_data,
  input  acc_kind_e         req_kind,
  input  logic [WORD_W-1:0] cmd_q,
  input  logic [WORD_W-1:0] blk_q,
  input  logic              cmd_pend,
  input  logic              blk_pend,
  output logic              cmd_we,
  output logic [WORD_W-1:0] cmd_wd,
  output logic              cmd_set,
  output logic              cmd_clr,
  output logic              blk_we,
  output logic [WORD_W-1:0] blk_wd,
  output logic              blk_set,
  output logic              blk_clr,
  output logic              ev_cmd_commit
);

  localparam logic [AW-1:0] BLK_DW_ADDR = AW'(BLK_DWORD_OFS);

  seq_state_e        st, st_nx;
  logic              r_write;
  logic [1:0]        r_size;
  logic [AW-1:0]     r_addr;
  logic [WORD_W-1:0] r_wdata;
  acc_kind_e         r_kind;
  logic [WORD_W-1:0] r_dw, dw_nx;
  logic [WORD_W-1:0] r_rsp, rsp_nx;
  logic [WORD_W-1:0] cmd_merged;
  logic [1:0]        h_ofs;
  logic              host_fire;
  logic              dev_fire;

  assign host_fire = host_valid && host_ready;
  assign dev_fire  = dev_valid && dev_ready;
  assign h_ofs     = host_addr[1:0];

  assign host_ready     = (st == S_IDLE);
  assign host_rsp_valid = (st == S_RESP);
  assign host_rsp_data  = r_rsp;

  assign dev_valid = (st == S_RD) || (st == S_WR) || (st == S_FLUSH) || (st == S_CMDW);
  assign dev_write = (st == S_WR) || (st == S_FLUSH) || (st == S_CMDW);
  assign dev_addr  = (st == S_FLUSH) ? BLK_DW_ADDR : {r_addr[AW-1:2], 2'b00};

  assign cmd_merged = lane_merge(cmd_q, r_wdata, SZ_HALF, r_addr[1:0]);

  always_comb begin
    case (st)
      S_FLUSH: dev_wdata = blk_q;
      S_CMDW:  dev_wdata = cmd_merged;
      default: dev_wdata = r_dw;
    endcase
  end

  assign ev_cmd_commit = (st == S_CMDW) && dev_fire;

  always_comb begin
    st_nx   = st;
    dw_nx   = r_dw;
    rsp_nx  = r_rsp;
    cmd_we  = 1'b0;
    cmd_wd  = cmd_merged;
    cmd_set = 1'b0;
    cmd_clr = 1'b0;
    blk_we  = 1'b0;
    blk_wd  = blk_q;
    blk_set = 1'b0;
    blk_clr = 1'b0;
    case (st)
      S_IDLE: begin
        if (host_fire) begin
          rsp_nx = '0;
          if (host_write) begin
            case (req_kind)
              K_WORD: begin
                dw_nx = host_wdata;
                st_nx = S_WR;
              end
              K_XFER: begin
                cmd_we  = 1'b1;
                cmd_wd  = lane_merge(cmd_q, host_wdata, SZ_HALF, h_ofs);
                cmd_set = 1'b1;
                st_nx   = S_RESP;
              end
              K_BLK: begin
                if (blk_pend) begin
                  blk_we  = 1'b1;
                  blk_wd  = lane_merge(blk_q, host_wdata, SZ_HALF, h_ofs);
                  blk_set = 1'b1;
                  st_nx   = S_RESP;
                end else begin
                  st_nx = S_RD;
                end
              end
              K_CMD:   st_nx = blk_pend ? S_FLUSH : S_CMDW;
              default: st_nx = S_RD;
            endcase
          end else begin
            if (req_kind == K_XFER && cmd_pend) begin
              rsp_nx = lane_pick(cmd_q, SZ_HALF, h_ofs);
              st_nx  = S_RESP;
            end else if (req_kind == K_BLK && blk_pend) begin
              rsp_nx = lane_pick(blk_q, SZ_HALF, h_ofs);
              st_nx  = S_RESP;
            end else begin
              st_nx = S_RD;
            end
          end
        end
      end
      S_RD: begin
        if (dev_fire) st_nx = S_RWAIT;
      end
      S_RWAIT: begin
        if (dev_rsp_valid) begin
          if (r_write) begin
            if (r_kind == K_BLK) begin
              blk_we  = 1'b1;
              blk_wd  = lane_merge(dev_rsp_data, r_wdata, r_size, r_addr[1:0]);
              blk_set = 1'b1;
              st_nx   = S_RESP;
            end else begin
              dw_nx = lane_merge(dev_rsp_data, r_wdata, r_size, r_addr[1:0]);
              st_nx = S_WR;
            end
          end else begin
            rsp_nx = (r_kind == K_WORD) ? dev_rsp_data
                                        : lane_pick(dev_rsp_data, r_size, r_addr[1:0]);
            st_nx  = S_RESP;
          end
        end
      end
      S_WR: begin
        if (dev_fire) st_nx = S_RESP;
      end
      S_FLUSH: begin
        if (dev_fire) begin
          blk_clr = 1'b1;
          st_nx   = S_CMDW;
        end
      end
      S_CMDW: begin
        if (dev_fire) begin
          cmd_we  = 1'b1;
          cmd_wd  = cmd_merged;
          cmd_clr = 1'b1;
          st_nx   = S_RESP;
        end
      end
      S_RESP:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      r_write <= 1'b0;
      r_size  <= 2'd0;
      r_addr  <= '0;
      r_wdata <= '0;
      r_kind  <= K_WORD;
      r_dw    <= '0;
      r_rsp   <= '0;
    end else begin
      st    <= st_nx;
      r_dw  <= dw_nx;
      r_rsp <= rsp_nx;
      if (host_fire) begin
        r_write <= host_write;
        r_size  <= host_size;
        r_addr  <= host_addr;
        r_wdata <= host_wdata;
        r_kind  <= req_kind;
      end
    end
  end

  // R11: a stalled device request does not change
  a_r11_dev_hold: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid && !dev_ready |=> dev_valid && $stable(dev_write) &&
                                $stable(dev_addr) && $stable(dev_wdata));

  // R10: one transaction at a time
  a_r10_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    host_fire |=> !host_ready);

  // R10: response is a single pulse
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> !host_rsp_valid);

  // R5: capturing transfer mode answers at once without the device
  a_r5_xfer_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_set |=> host_rsp_valid && !dev_valid);

  // R8: a pending shadow read answers the next cycle
  a_r8_shadow_read: assert property (@(posedge clk) disable iff (!rst_n)
    host_fire && !host_write && req_kind == K_BLK && blk_pend |=> host_rsp_valid);

endmodule

// File: rtl/subword_reg_adapter.sv
module subword_reg_adapter
  import sra_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int BLKSZ_OFS  = 4,
  parameter int BLKCNT_OFS = 6,
  parameter int XFER_OFS   = 12,
  parameter int CMD_OFS    = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic              host_write,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [1:0]        host_size,
  input  logic [31:0]       host_wdata,
  output logic              host_rsp_valid,
  output logic [31:0]       host_rsp_data,
  output logic              dev_valid,
  input  logic              dev_ready,
  output logic              dev_write,
  output logic [ADDR_W-1:0] dev_addr,
  output logic [31:0]       dev_wdata,
  input  logic              dev_rsp_valid,
  input  logic [31:0]       dev_rsp_data
);

  localparam int BLK_DWORD = BLKSZ_OFS - (BLKSZ_OFS % 4);

  acc_kind_e         req_kind;
  logic [WORD_W-1:0] cmd_q, blk_q;
  logic              cmd_pend, blk_pend;
  logic              cmd_we, cmd_set, cmd_clr;
  logic              blk_we, blk_set, blk_clr;
  logic [WORD_W-1:0] cmd_wd, blk_wd;
  logic              ev_cmd_commit;

  sra_decode #(
    .AW(ADDR_W), .BLKSZ_OFS(BLKSZ_OFS), .BLKCNT_OFS(BLKCNT_OFS),
    .XFER_OFS(XFER_OFS), .CMD_OFS(CMD_OFS)
  ) u_decode (
    .addr (host_addr),
    .size (host_size),
    .kind (req_kind)
  );

  sra_shadow u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_we     (cmd_we),
    .cmd_wd     (cmd_wd),
    .cmd_set    (cmd_set),
    .cmd_clr    (cmd_clr),
    .blk_we     (blk_we),
    .blk_wd     (blk_wd),
    .blk_set    (blk_set),
    .blk_clr    (blk_clr),
    .cmd_commit (ev_cmd_commit),
    .cmd_q      (cmd_q),
    .blk_q      (blk_q),
    .cmd_pend   (cmd_pend),
    .blk_pend   (blk_pend)
  );

  sra_seq #(
    .AW(ADDR_W), .BLK_DWORD_OFS(BLK_DWORD)
  ) u_seq (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_valid     (host_valid),
    .host_ready     (host_ready),
    .host_write     (host_write),
    .host_addr      (host_addr),
    .host_size      (host_size),
    .host_wdata     (host_wdata),
    .host_rsp_valid (host_rsp_valid),
    .host_rsp_data  (host_rsp_data),
    .dev_valid      (dev_valid),
    .dev_ready      (dev_ready),
    .dev_write      (dev_write),
    .dev_addr       (dev_addr),
    .dev_wdata      (dev_wdata),
    .dev_rsp_valid  (dev_rsp_valid),
    .dev_rsp_data   (dev_rsp_data),
    .req_kind       (req_kind),
    .cmd_q          (cmd_q),
    .blk_q          (blk_q),
    .cmd_pend       (cmd_pend),
    .blk_pend       (blk_pend),
    .cmd_we         (cmd_we),
    .cmd_wd         (cmd_wd),
    .cmd_set        (cmd_set),
    .cmd_clr        (cmd_clr),
    .blk_we         (blk_we),
    .blk_wd         (blk_wd),
    .blk_set        (blk_set),
    .blk_clr        (blk_clr),
    .ev_cmd_commit  (ev_cmd_commit)
  );

  // R2: device side only ever sees dword-aligned addresses
  a_r2_dev_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    dev_valid |-> dev_addr[1:0] == 2'b00);

endmodule

// File: tb/tb_subword_reg_adapter.sv
module tb_subword_reg_adapter;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0;
  logic        host_ready;
  logic        host_write = 1'b0;
  logic [7:0]  host_addr = '0;
  logic [1:0]  host_size = '0;
  logic [31:0] host_wdata = '0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_data;
  logic        dev_valid;
  logic        dev_ready = 1'b0;
  logic        dev_write;
  logic [7:0]  dev_addr;
  logic [31:0] dev_wdata;
  logic        dev_rsp_valid = 1'b0;
  logic [31:0] dev_rsp_data = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  subword_reg_adapter dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready), .host_write(host_write),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rsp_valid(host_rsp_valid), .host_rsp_data(host_rsp_data),
    .dev_valid(dev_valid), .dev_ready(dev_ready), .dev_write(dev_write),
    .dev_addr(dev_addr), .dev_wdata(dev_wdata),
    .dev_rsp_valid(dev_rsp_valid), .dev_rsp_data(dev_rsp_data)
  );

  int checks = 0;
  int fails  = 0;
  int ds_reads = 0;
  int cyc = 0;
  int rd_cnt = 0;
  logic [31:0] rd_data = '0;
  string cur_tag = "R1";

  logic [31:0] mem     [0:63];
  logic [31:0] ref_mem [0:63];
  logic [31:0] ref_cmd = '0, ref_blk = '0;
  bit          ref_cmd_p = 0, ref_blk_p = 0;
  logic [63:0] exp_wq [$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] put_lanes(input logic [31:0] old, input logic [31:0] val,
                                            input int nb, input int ofs);
    logic [31:0] r = old;
    for (int i = 0; i < nb; i++) r[(ofs+i)*8 +: 8] = val[i*8 +: 8];
    return r;
  endfunction

  function automatic logic [31:0] get_lanes(input logic [31:0] dw, input int nb, input int ofs);
    logic [31:0] r = '0;
    for (int i = 0; i < nb; i++) r[i*8 +: 8] = dw[(ofs+i)*8 +: 8];
    return r;
  endfunction

  // Behavioural reference: expected read data, device reads and device writes
  task automatic ref_do(input bit w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] er, output int nrd);
    int ofs = int'(a[1:0]);
    int dwi = int'(a[7:2]);
    int nb  = (sz == 2'd0) ? 1 : 2;
    logic [31:0] nv;
    er = '0; nrd = 0;
    if (sz[1]) begin
      if (w) begin
        exp_wq.push_back({32'(a & 8'hFC), wd});
        ref_mem[dwi] = wd;
      end else begin
        er = ref_mem[dwi]; nrd = 1;
      end
    end else if (sz == 2'd1 && a == 8'h0C && w) begin
      ref_cmd = put_lanes(ref_cmd, wd, 2, 0); ref_cmd_p = 1;
    end else if (sz == 2'd1 && (a == 8'h04 || a == 8'h06) && w) begin
      if (!ref_blk_p) begin ref_blk = ref_mem[1]; nrd = 1; end
      ref_blk = put_lanes(ref_blk, wd, 2, ofs); ref_blk_p = 1;
    end else if (sz == 2'd1 && a == 8'h0E && w) begin
      if (ref_blk_p) begin
        exp_wq.push_back({32'h4, ref_blk});
        ref_mem[1] = ref_blk; ref_blk_p = 0;
      end
      ref_cmd = put_lanes(ref_cmd, wd, 2, 2);
      exp_wq.push_back({32'hC, ref_cmd});
      ref_mem[3] = ref_cmd; ref_cmd_p = 0;
    end else if (w) begin
      nv = put_lanes(ref_mem[dwi], wd, nb, ofs);
      nrd = 1;
      exp_wq.push_back({32'(a & 8'hFC), nv});
      ref_mem[dwi] = nv;
    end else if (sz == 2'd1 && a == 8'h0C && ref_cmd_p) begin
      er = get_lanes(ref_cmd, 2, 0);
    end else if (sz == 2'd1 && (a == 8'h04 || a == 8'h06) && ref_blk_p) begin
      er = get_lanes(ref_blk, 2, ofs);
    end else begin
      er = get_lanes(ref_mem[dwi], nb, ofs); nrd = 1;
    end
  endtask

  // Device model and per-clock comparison of device writes
  always @(negedge clk) begin
    logic [63:0] e;
    cyc++;
    dev_ready = (cyc % 3) != 1;
    dev_rsp_valid = 1'b0;
    if (rd_cnt > 0) begin
      rd_cnt--;
      if (rd_cnt == 0) begin
        dev_rsp_valid = 1'b1;
        dev_rsp_data  = rd_data;
      end
    end
    if (rst_n && dev_valid && dev_ready) begin
      if (dev_write) begin
        if (exp_wq.size() == 0) begin
          chk(0, cur_tag, "unexpected device write", dev_wdata, 32'h0);
        end else begin
          e = exp_wq.pop_front();
          chk(e == {32'(dev_addr), dev_wdata}, cur_tag, "device write (addr,data)",
              {dev_addr, dev_wdata[23:0]}, {e[39:32], e[23:0]});
        end
        mem[dev_addr[7:2]] = dev_wdata;
      end else begin
        ds_reads++;
        rd_data = mem[dev_addr[7:2]];
        rd_cnt  = 1 + (cyc % 2);
      end
    end
  end

  task automatic access(input bit w, input logic [1:0] sz, input logic [7:0] a,
                        input logic [31:0] wd, input string tag);
    logic [31:0] er, got;
    int nrd, rd0;
    ref_do(w, sz, a, wd, er, nrd);
    cur_tag = tag;
    rd0 = ds_reads;
    @(negedge clk);
    host_valid = 1'b1; host_write = w; host_size = sz; host_addr = a; host_wdata = wd;
    while (!host_ready) @(negedge clk);
    @(negedge clk);
    host_valid = 1'b0;
    chk(!host_ready, "R10", "ready dropped after accept", 32'(host_ready), 32'h0);
    while (!host_rsp_valid) @(negedge clk);
    got = host_rsp_data;
    if (!w) chk(got == er, tag, "read data", got, er);
    chk(ds_reads - rd0 == nrd, tag, "device read count", 32'(ds_reads - rd0), 32'(nrd));
    chk(exp_wq.size() == 0, tag, "missing device writes", 32'(exp_wq.size()), 32'h0);
    @(negedge clk);
    chk(!host_rsp_valid, "R10", "single response pulse", 32'(host_rsp_valid), 32'h0);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    ref_cmd = '0; ref_blk = '0; ref_cmd_p = 0; ref_blk_p = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog expired act=%0d exp=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    int seed = 7;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 32'h1000_0000 + i * 32'h0102_0304;
      ref_mem[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: idle after reset
    chk(host_ready == 1'b1, "R1", "ready after reset", 32'(host_ready), 32'h1);
    chk(dev_valid == 1'b0, "R1", "no device request", 32'(dev_valid), 32'h0);
    chk(host_rsp_valid == 1'b0, "R1", "no response", 32'(host_rsp_valid), 32'h0);

    access(1, 2'd2, 8'h10, 32'hDEAD_BEEF, "R2");
    access(0, 2'd2, 8'h10, 32'h0, "R2");
    access(1, 2'd0, 8'h11, 32'h0000_0055, "R3");
    access(1, 2'd0, 8'h13, 32'h0000_00A7, "R3");
    access(1, 2'd1, 8'h16, 32'h0000_C0DE, "R3");
    access(0, 2'd2, 8'h14, 32'h0, "R3");
    access(0, 2'd0, 8'h12, 32'h0, "R4");
    access(0, 2'd0, 8'h17, 32'h0, "R4");
    access(0, 2'd1, 8'h0A, 32'h0, "R9");

    access(1, 2'd1, 8'h0C, 32'h0000_0033, "R5");
    access(0, 2'd1, 8'h0C, 32'h0, "R8");
    access(0, 2'd0, 8'h0C, 32'h0, "R4");
    access(1, 2'd1, 8'h04, 32'h0000_0200, "R6");
    access(1, 2'd1, 8'h06, 32'h0000_0008, "R6");
    access(0, 2'd1, 8'h04, 32'h0, "R8");
    access(0, 2'd1, 8'h06, 32'h0, "R8");
    access(1, 2'd1, 8'h0E, 32'h0000_113A, "R7");
    access(0, 2'd2, 8'h04, 32'h0, "R7");
    access(0, 2'd2, 8'h0C, 32'h0, "R7");
    access(0, 2'd1, 8'h0C, 32'h0, "R9");
    access(0, 2'd1, 8'h06, 32'h0, "R9");
    access(1, 2'd1, 8'h0C, 32'h0000_0012, "R5");
    access(1, 2'd1, 8'h0E, 32'h0000_0C1B, "R7");
    access(1, 2'd1, 8'h0E, 32'h0000_0D00, "R7");

    // R1: reset drops a pending transfer-mode shadow
    access(1, 2'd1, 8'h0C, 32'h0000_7777, "R5");
    do_reset();
    access(0, 2'd1, 8'h0C, 32'h0, "R1");
    access(1, 2'd1, 8'h06, 32'h0000_0044, "R6");
    do_reset();
    access(0, 2'd1, 8'h06, 32'h0, "R1");

    for (int n = 0; n < 40; n++) begin
      logic [7:0] a;
      logic [1:0] sz;
      bit w;
      seed = seed * 1103515245 + 12345;
      a  = 8'h20 + 8'((seed >>> 8) & 31);
      sz = 2'((seed >>> 16) % 3);
      w  = ((seed >>> 20) & 1) != 0;
      if (sz == 2'd1) a[0] = 1'b0;
      if (sz == 2'd2) a[1:0] = 2'b00;
      if (sz == 2'd2)      access(w, sz, a, 32'(seed), "R2");
      else if (w)          access(w, sz, a, 32'(seed), "R3");
      else if (sz == 2'd0) access(w, sz, a, 32'(seed), "R4");
      else                 access(w, sz, a, 32'(seed), "R9");
    end

    begin
      int bad = 0;
      for (int i = 0; i < 64; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk(bad == 0, "R3", "device contents vs model", 32'(bad), 32'h0);
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

endmodule